// File: doc/BRIEF.md
# LED Matrix Row Scanner

This block lights a small LED matrix one row at a time. A free-running prescaler counts clock cycles. When it reaches its terminal count it raises a strobe for exactly one cycle and then starts again from zero. Each strobe moves a one-hot row select to the next row. In that same cycle the column drive register loads the stored image line that belongs to the row now selected. Scanning fast enough makes the whole image appear at once. The stored image is a smiley face, and its column levels are active-low, so a 0 turns an LED on.

The prescaler terminal count is a parameter. Hardware uses a long period, and the default is a one-second step from a 100 MHz clock. A simulation can set a period of a few cycles. The number of rows, the number of columns, the image contents and the column polarity are also parameters.

Top module: `led_row_scanner`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `row_sel` = 8'h01 (row 0) and `col_drv` = 8'hFF (every LED dark).
- R2: Both outputs change only on the clock edge that ends a prescaler period. A period is TERM_COUNT+1 cycles, and the first period starts on the first edge after reset is released. At every other edge both outputs keep their values.
- R3: `row_sel` always has exactly one bit set.
- R4: On a strobe, the set bit in `row_sel` moves one position toward the MSB, so bit k becomes bit k+1.
- R5: On a strobe while bit 7 is set, `row_sel` returns to bit 0 (8'h01).
- R6: After a strobe, `col_drv` holds the active-low line of the row that `row_sel` selects in that same cycle. The lines for rows 0 to 7 are FF, DB, DB, FF, 3C, 81, C3, FF, where row k is bit k of `row_sel`.
- R7: The pair (`row_sel`, `col_drv`) repeats exactly every 8 strobes.
- R8: Asserting reset in the middle of a scan returns the block to the R1 state on the next edge. The prescaler restarts from zero, so the next row step comes a full period after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_sel | output | 8 | One-hot row select; bit k drives row k |
| col_drv | output | 8 | Column drive for the selected row, active-low |

## Verification
- **Prescaler fault:** a prescaler that is stuck or miscounting shows up as a row step in the wrong cycle. The bench catches it within one period, because it checks both outputs at every cycle, not only at strobes.
- **Row pointer fault:** a row pointer that loses or gains a bit breaks the one-hot pattern at the next strobe. A pointer that fails to wrap gives a wrong value at the eighth strobe.
- **Column misalignment:** a column line taken for the old row instead of the new one gives a column mismatch at the first strobe. The line for row 1 (DB) differs from the line for row 0 (FF).

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
   localparam int unsigned SCAN_ROWS = 8;
   localparam int unsigned SCAN_COLS = 8;
   // Line for row k sits at [k*SCAN_COLS +: SCAN_COLS]; active-low (0 = lit)
   localparam logic [SCAN_ROWS*SCAN_COLS-1:0] SMILEY_IMAGE = {
      8'hFF, 8'hC3, 8'h81, 8'h3C, 8'hFF, 8'hDB, 8'hDB, 8'hFF
   };
endpackage

// File: rtl/scan_tick.sv
module scan_tick #(
   parameter int unsigned TERM_COUNT = 99_999_999,
   localparam int unsigned CNT_W = (TERM_COUNT < 1) ? 1 : $clog2(TERM_COUNT + 1)
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM_COUNT);

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == TERM_V);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/row_ring.sv
module row_ring #(
   parameter int unsigned ROWS = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   output logic [ROWS-1:0] row_q,
   output logic [ROWS-1:0] row_nxt
);
   // Rotate toward the MSB; the top bit feeds bit 0
   for (genvar i = 0; i < ROWS; i++) begin : g_rot
      assign row_nxt[i] = row_q[(i + ROWS - 1) % ROWS];
   end

   always_ff @(posedge clk) begin
      if (rst)      row_q <= ROWS'(1);
      else if (adv) row_q <= row_nxt;
   end
endmodule

// File: rtl/col_select.sv
module col_select #(
   parameter int unsigned ROWS = 8,
   parameter int unsigned COLS = 8,
   parameter logic [ROWS*COLS-1:0] IMAGE = '1
) (
   input  logic [ROWS-1:0] sel,
   output logic [COLS-1:0] line
);
   logic [COLS-1:0] term [ROWS];

   for (genvar i = 0; i < ROWS; i++) begin : g_term
      assign term[i] = {COLS{sel[i]}} & IMAGE[i*COLS +: COLS];
   end

   always_comb begin
      line = '0;
      for (int i = 0; i < ROWS; i++) line = line | term[i];
   end
endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner #(
   parameter int unsigned ROWS = led_scan_pkg::SCAN_ROWS,
   parameter int unsigned COLS = led_scan_pkg::SCAN_COLS,
   parameter int unsigned TERM_COUNT = 99_999_999,
   parameter bit COL_ACTIVE_LOW = 1'b1,
   parameter logic [ROWS*COLS-1:0] IMAGE = led_scan_pkg::SMILEY_IMAGE
) (
   input  logic            clk,
   input  logic            rst,
   output logic [ROWS-1:0] row_sel,
   output logic [COLS-1:0] col_drv
);
   localparam logic [COLS-1:0] IDLE = {COLS{COL_ACTIVE_LOW}};

   if (ROWS < 2)       begin : g_bad_rows $error("ROWS must be at least 2"); end
   if (COLS < 1)       begin : g_bad_cols $error("COLS must be at least 1"); end
   if (TERM_COUNT < 1) begin : g_bad_term $error("TERM_COUNT must be at least 1"); end

   logic            strobe;
   logic [ROWS-1:0] row_nxt;
   logic [COLS-1:0] line;
   logic [COLS-1:0] line_drv;
   logic [COLS-1:0] col_q;

   scan_tick #(.TERM_COUNT(TERM_COUNT)) u_tick (
      .clk (clk),
      .rst (rst),
      .tick(strobe)
   );

   row_ring #(.ROWS(ROWS)) u_ring (
      .clk    (clk),
      .rst    (rst),
      .adv    (strobe),
      .row_q  (row_sel),
      .row_nxt(row_nxt)
   );

   // Line is looked up for the row about to be selected, so both load together
   col_select #(.ROWS(ROWS), .COLS(COLS), .IMAGE(IMAGE)) u_col (
      .sel (row_nxt),
      .line(line)
   );

   if (COL_ACTIVE_LOW) begin : g_low
      assign line_drv = line;
   end else begin : g_high
      assign line_drv = ~line;
   end

   always_ff @(posedge clk) begin
      if (rst)         col_q <= IDLE;
      else if (strobe) col_q <= line_drv;
   end

   assign col_drv = col_q;
endmodule

// File: rtl/led_row_scanner_chk.sv
module led_row_scanner_chk #(
   parameter int unsigned ROWS = 8,
   parameter int unsigned COLS = 8,
   parameter int unsigned TERM_COUNT = 99_999_999,
   parameter bit COL_ACTIVE_LOW = 1'b1,
   parameter logic [ROWS*COLS-1:0] IMAGE = '1
) (
   input logic            clk,
   input logic            rst,
   input logic [ROWS-1:0] row_sel,
   input logic [COLS-1:0] col_drv
);
   localparam int unsigned CW = (TERM_COUNT < 1) ? 1 : $clog2(TERM_COUNT + 1);
   localparam logic [CW-1:0] TV = CW'(TERM_COUNT);
   localparam logic [COLS-1:0] IDLE = {COLS{COL_ACTIVE_LOW}};

   logic [CW-1:0]   k_q;
   logic            seen_q;
   logic [COLS-1:0] exp_col;

   always_ff @(posedge clk) begin
      if (rst) begin
         k_q    <= '0;
         seen_q <= 1'b0;
      end else begin
         k_q <= (k_q == TV) ? '0 : k_q + 1'b1;
         if (k_q == TV) seen_q <= 1'b1;
      end
   end

   always_comb begin
      exp_col = '0;
      for (int i = 0; i < ROWS; i++)
         if (row_sel[i]) exp_col = IMAGE[i*COLS +: COLS];
      if (!COL_ACTIVE_LOW) exp_col = ~exp_col;
   end

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (row_sel == ROWS'(1) && col_drv == IDLE)); // R1
   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(row_sel) == 1); // R3
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
      (k_q != TV) |=> ($stable(row_sel) && $stable(col_drv))); // R2
   AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
      (k_q == TV && !row_sel[ROWS-1]) |=> row_sel == ($past(row_sel) << 1)); // R4
   AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
      (k_q == TV && row_sel[ROWS-1]) |=> row_sel == ROWS'(1)); // R5
   AST_COL_ALIGN: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> col_drv == exp_col); // R6
endmodule

bind led_row_scanner led_row_scanner_chk #(
   .ROWS(ROWS), .COLS(COLS), .TERM_COUNT(TERM_COUNT),
   .COL_ACTIVE_LOW(COL_ACTIVE_LOW), .IMAGE(IMAGE)
) u_chk (
   .clk(clk), .rst(rst), .row_sel(row_sel), .col_drv(col_drv)
);

// File: tb/tb_led_row_scanner.sv
module tb_led_row_scanner;
   localparam int unsigned TERM = 4;
   localparam int unsigned PERIOD = TERM + 1;

   // {row_sel, col_drv} after strobe n+1; second half repeats the first (R7)
   localparam logic [15:0] EXP [16] = '{
      16'h02DB, 16'h04DB, 16'h08FF, 16'h103C, 16'h2081, 16'h40C3, 16'h80FF, 16'h01FF,
      16'h02DB, 16'h04DB, 16'h08FF, 16'h103C, 16'h2081, 16'h40C3, 16'h80FF, 16'h01FF
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] row_sel;
   logic [7:0] col_drv;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   led_row_scanner #(.TERM_COUNT(TERM)) dut (
      .clk(clk), .rst(rst), .row_sel(row_sel), .col_drv(col_drv)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog R2 actual %0d expected <=5000", cyc);
         summary();
      end
   end

   initial begin
      logic [15:0] prev;
      logic [15:0] s3;
      repeat (3) @(negedge clk);
      check("R1 reset state", {row_sel, col_drv}, 16'h01FF);
      rst = 1'b0;
      prev = 16'h01FF;
      // Table walk: hold for TERM cycles, then step on cycle PERIOD
      for (int s = 0; s < 16; s++) begin
         for (int c = 1; c <= int'(PERIOD); c++) begin
            @(negedge clk);
            if (c < int'(PERIOD))
               check("R2 hold between strobes", {row_sel, col_drv}, prev);
            else
               check("R4/R5/R6 strobe vector", {row_sel, col_drv}, EXP[s]);
         end
         prev = {row_sel, col_drv};
         if (s == 2) s3 = prev;
         if (s == 10) check("R7 repeat after 8 strobes", prev, s3);
         if (s == 6) check("R3 one-hot at top row", {8'h0, row_sel}, 16'h0080);
         if (s == 7) check("R5 wrap to row 0", {8'h0, row_sel}, 16'h0001);
      end
      // Two more strobes, then reset mid-scan
      repeat (2 * PERIOD) @(negedge clk);
      check("R4 mid-scan position", {row_sel, col_drv}, 16'h04DB);
      rst = 1'b1;
      @(negedge clk);
      check("R8 reset mid-scan", {row_sel, col_drv}, 16'h01FF);
      repeat (2 * PERIOD) @(negedge clk);
      check("R8 reset holds through periods", {row_sel, col_drv}, 16'h01FF);
      rst = 1'b0;
      repeat (TERM) @(negedge clk);
      check("R8 prescaler restarted, no early step", {row_sel, col_drv}, 16'h01FF);
      @(negedge clk);
      check("R8 first step one period after reset", {row_sel, col_drv}, 16'h02DB);
      repeat (PERIOD) @(negedge clk);
      check("R6 row 2 line", {row_sel, col_drv}, 16'h04DB);
      summary();
   end
endmodule